// File: doc/BRIEF.md
# Preset Decimal Down-Count Pulse Divider

This block divides an input clock by a number set on decimal switches and emits one fixed-width pulse per division period. The switch value arrives as packed BCD digits. A decimal down-counter is loaded from that value, counts down to zero, and then hands over to a short trailing stage of eight clocks. When the trailing stage finishes, the output register is set and the division pulse begins. A separate width counter clears the output register 40 clocks later.

Between two count-downs the control runs a three-step reload. First the counter is frozen. Then it is cleared. Then the switch value is copied in. Each step takes one clock. The switch inputs are read only in the copy step, so the switches can be moved at any time without disturbing the count in progress. Digit codes above nine are read as nine. An all-zero setting is read as one, so the pulse train never stops. With an effective setting Neff, one full period is Neff + 12 input clocks.

Top module: `thumbwheel_divider`

## Requirements
- R1: While reset is asserted the output is low. After reset is released, the first rising edge of the output appears at the (Neff+12)-th clock edge.
- R2: Successive rising edges of the output are exactly Neff+12 clocks apart. This is made up of Neff+1 counting clocks, 8 trailing clocks and 3 reload clocks.
- R3: When the period exceeds 40 clocks, the output stays high for exactly 40 clocks in each period.
- R4: When the period is 40 clocks or less, the output is re-set before it can clear, so it stays high continuously after its first rise.
- R5: Digit i of the setting occupies bits 4i+3..4i, with digit 0 the least significant decimal digit. Any digit code from 10 to 15 is treated as 9.
- R6: A setting whose digits are all zero is treated as 1.
- R7: The setting is sampled only in the preload step. A change made at any other time has no effect until the next reload.
- R8: The reload always runs as inhibit, then initialize, then preload, each lasting one clock. The counter holds its value during inhibit, reads zero after initialize, and is non-zero after preload.
- R9: Every counter digit always holds a valid decimal value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input signal to be divided; all registers use its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| thumbSetting | input | 4*DIGITS | Packed BCD division setting, digit 0 in the low nibble |
| pulseOut | output | 1 | Divide-by-N pulse |

## Verification
The assertions watch the reload sequence on every cycle. They check that inhibit freezes the counter, that initialize clears it and that preload leaves a non-zero value. They also check that every digit stays in the decimal range, that a strobe never overlaps another, and that the output only rises right after the control's set strobe. The exact period, the 40-clock width, the steady-high case for short periods, the clamping of illegal digits and the treatment of a zero setting show up only as edge timing on the output. The bench measures these by sweeping every 8-bit code of a two-digit configuration. It also covers a setting changed in the middle of a count, which must leave the current period untouched.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

  typedef enum logic [2:0] {
    PH_INHIBIT = 3'd0,
    PH_INIT    = 3'd1,
    PH_PRELOAD = 3'd2,
    PH_COUNT   = 3'd3,
    PH_TAIL    = 3'd4
  } phase_e;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic inhibit;
    logic init;
    logic preload;
    logic decrement;
    logic setPulse;
  } ctlStrobes_t;

endpackage

// File: rtl/tdiv_digit.sv
// One decimal digit of the down-counter: borrow wraps 0 to 9.
module tdiv_digit (
  input  logic [3:0] curDigit,
  input  logic       borrowIn,
  output logic [3:0] nextDigit
);
  always_comb begin
    if (!borrowIn)            nextDigit = curDigit;
    else if (curDigit == 4'd0) nextDigit = 4'd9;
    else                      nextDigit = curDigit - 4'd1;
  end
endmodule

// File: rtl/tdiv_control.sv
module tdiv_control
  import tdiv_pkg::*;
#(
  parameter int TAIL_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        countZero,
  output ctlStrobes_t strobes
);
  localparam int TW = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1;
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_LEN - 1);

  phase_e         state, stateNext;
  logic [TW-1:0]  tailCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_INHIBIT: stateNext = PH_INIT;
      PH_INIT:    stateNext = PH_PRELOAD;
      PH_PRELOAD: stateNext = PH_COUNT;
      PH_COUNT:   if (countZero) stateNext = PH_TAIL;
      PH_TAIL:    if (tailCnt == TAIL_LAST) stateNext = PH_INHIBIT;
      default:    stateNext = PH_INHIBIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PH_INHIBIT;
      tailCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == PH_TAIL) tailCnt <= tailCnt + TW'(1);
      else                  tailCnt <= '0;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.inhibit   = (state == PH_INHIBIT);
    strobes.init      = (state == PH_INIT);
    strobes.preload   = (state == PH_PRELOAD);
    strobes.decrement = (state == PH_COUNT) && !countZero;
    strobes.setPulse  = (state == PH_TAIL) && (tailCnt == TAIL_LAST);
  end

  // R8: reload steps follow each other, one clock each
  assert_inhibit_to_init_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_INHIBIT |=> state == PH_INIT);
  assert_init_to_preload_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_INIT |=> state == PH_PRELOAD);
  assert_preload_to_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_PRELOAD |=> state == PH_COUNT);
  // R2: the pulse set is followed by a fresh reload
  assert_set_then_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setPulse |=> state == PH_INHIBIT);
  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/tdiv_datapath.sv
module tdiv_datapath
  import tdiv_pkg::*;
#(
  parameter int DIGITS    = 3,
  parameter int PULSE_LEN = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [4*DIGITS-1:0]   thumbSetting,
  output logic                  countZero,
  output logic                  pulseOut
);
  localparam int WW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [WW-1:0] WIDTH_LAST = WW'(PULSE_LEN - 1);

  logic [DIGITS-1:0][3:0] cntReg, decNext, clampDigit, loadVal;
  logic [DIGITS-1:0]      lowerZero;
  logic [WW-1:0]          widthCnt;
  logic                   outReg;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] rawDigit;
    assign rawDigit      = thumbSetting[4*i +: 4];
    assign clampDigit[i] = (rawDigit > 4'd9) ? 4'd9 : rawDigit;

    if (i == 0) begin : g_low
      assign lowerZero[i] = 1'b1;
    end else begin : g_high
      assign lowerZero[i] = (cntReg[i-1:0] == '0);
    end

    tdiv_digit u_digit (
      .curDigit  (cntReg[i]),
      .borrowIn  (lowerZero[i]),
      .nextDigit (decNext[i])
    );

    // R9: each digit stays decimal
    assert_digit_bcd_R9: assert property (@(posedge clk) disable iff (!rstN)
      cntReg[i] <= 4'd9);
  end

  always_comb begin
    loadVal = clampDigit;
    if (clampDigit == '0) loadVal[0] = 4'd1;
  end

  assign countZero = (cntReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobes.inhibit) begin
      cntReg <= cntReg;
    end else if (strobes.init) begin
      cntReg <= '0;
    end else if (strobes.preload) begin
      cntReg <= loadVal;
    end else if (strobes.decrement) begin
      cntReg <= decNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg   <= 1'b0;
      widthCnt <= '0;
    end else if (strobes.setPulse) begin
      outReg   <= 1'b1;
      widthCnt <= WIDTH_LAST;
    end else if (outReg) begin
      if (widthCnt == '0) outReg <= 1'b0;
      else                widthCnt <= widthCnt - WW'(1);
    end
  end

  assign pulseOut = outReg;

  assert_inhibit_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inhibit |=> $stable(cntReg));
  assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.init |=> cntReg == '0);
  // R6: a preload never leaves a zero count
  assert_preload_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.preload |=> cntReg != '0);
  assert_decrement_moves_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decrement |=> cntReg != $past(cntReg));
  assert_rise_after_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(strobes.setPulse));

endmodule

// File: rtl/thumbwheel_divider.sv
module thumbwheel_divider
  import tdiv_pkg::*;
#(
  parameter int DIGITS    = 3,
  parameter int TAIL_LEN  = 8,
  parameter int PULSE_LEN = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4*DIGITS-1:0] thumbSetting,
  output logic                pulseOut
);
  ctlStrobes_t strobes;
  logic        countZero;

  tdiv_control #(.TAIL_LEN(TAIL_LEN)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .countZero (countZero),
    .strobes   (strobes)
  );

  tdiv_datapath #(.DIGITS(DIGITS), .PULSE_LEN(PULSE_LEN)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .thumbSetting (thumbSetting),
    .countZero    (countZero),
    .pulseOut     (pulseOut)
  );
endmodule

// File: tb/tb_thumbwheel_divider.sv
`timescale 1ns/1ps
module tb_thumbwheel_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] setting = 8'h00;
  logic       pulseOut;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  thumbwheel_divider #(.DIGITS(2), .TAIL_LEN(8), .PULSE_LEN(40)) dut (
    .clk(clk), .rstN(rstN), .thumbSetting(setting), .pulseOut(pulseOut));

  function automatic int effN(input logic [7:0] c);
    int hi, lo, v;
    hi = (c[7:4] > 4'd9) ? 9 : int'(c[7:4]);  // R5
    lo = (c[3:0] > 4'd9) ? 9 : int'(c[3:0]);
    v  = hi * 10 + lo;
    if (v == 0) v = 1;                          // R6
    return v;
  endfunction

  task automatic checkEq(input string tag, input int actual, input int expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Reset with a setting; leaves time just before clock edge 1.
  task automatic resetWith(input logic [7:0] code);
    @(negedge clk); rstN = 1'b0; setting = code;
    repeat (2) @(negedge clk);
    checkEq("R1 low in reset", int'(pulseOut), 0);
    rstN = 1'b1;
  endtask

  task automatic measure(input logic [7:0] code);
    int n, p, e, rise, fall, rise2, highCnt;
    string tag;
    n = effN(code); p = n + 12; e = 0; rise = -1; fall = -1; rise2 = -1;
    resetWith(code);
    while (rise < 0 && e < 400) begin @(negedge clk); e++; if (pulseOut) rise = e; end
    checkEq($sformatf("R1 first rise code=%02h", code), rise, p);
    if ((code[7:4] > 4'd9) || (code[3:0] > 4'd9)) tag = "R5";
    else if (code == 8'h00) tag = "R6";
    else tag = "R2";
    if (p > 40) begin
      while (fall < 0 && e < 800) begin @(negedge clk); e++; if (!pulseOut) fall = e; end
      checkEq($sformatf("R3 width code=%02h", code), fall - rise, 40);
      while (rise2 < 0 && e < 800) begin @(negedge clk); e++; if (pulseOut) rise2 = e; end
      checkEq($sformatf("%s period code=%02h", tag, code), rise2 - rise, p);
    end else begin
      highCnt = 0;
      for (int k = 0; k < 2 * p; k++) begin @(negedge clk); if (pulseOut) highCnt++; end
      checkEq($sformatf("R4 steady high code=%02h (%s)", code, tag), highCnt, 2 * p);
    end
  endtask

  initial begin
    #700000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int e, rise, rise2, fall;
    // R7: change 50 -> 40 mid-count; first period keeps 50, next uses 40
    resetWith(8'h50);
    e = 0; rise = -1; rise2 = -1; fall = -1;
    while (rise < 0 && e < 400) begin
      @(negedge clk); e++;
      if (e == 20) setting = 8'h40;
      if (pulseOut) rise = e;
    end
    checkEq("R7 first rise unchanged", rise, 62);
    while (fall < 0 && e < 400) begin @(negedge clk); e++; if (!pulseOut) fall = e; end
    while (rise2 < 0 && e < 400) begin @(negedge clk); e++; if (pulseOut) rise2 = e; end
    checkEq("R7 new period after reload", rise2 - rise, 52);

    // R1: reset in the middle of a pulse drops the output
    resetWith(8'h60);
    repeat (80) @(negedge clk);
    checkEq("R1 pulse high before reset", int'(pulseOut), 1);
    rstN = 1'b0;
    @(negedge clk);
    checkEq("R1 reset clears pulse", int'(pulseOut), 0);

    // Exhaustive sweep of every two-digit code (R2..R6)
    for (int c = 0; c < 256; c++) measure(8'(c));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule